// File: doc/BRIEF.md
# PRBS-7 Word Generator and Checker

This block is a built-in self-test for a 10-bit parallel transmit/receive path. When the test enable is high, a 7-bit linear feedback shift register produces a pseudorandom bit sequence with a period of 127 bits. The block packs ten consecutive bits per clock into a transmit word, and that word replaces the user's parallel transmit data. When the enable is low, the user's word passes straight through.

The same enable starts a receive-side checker. The checker takes its starting state from the first received word. From then on it predicts every incoming bit from the bits that came in before it, so it locks to the sequence at any phase without a training step. A single pass flag reports the result. In live mode the flag follows the most recent word. In sticky mode one failure holds the flag low until the test is restarted.

Top module: `prbs_bist`

## Requirements
- R1: While reset is asserted, and on the first clock after reset, passFlag is 1. The generator state is loaded so that the first word after the enable rises comes from seven 1-bits of history.
- R2: While testEn is 0, txDataOut equals txDataIn. passFlag is 1 from the clock edge after testEn is sampled low.
- R3: While testEn is 1, txDataOut carries the generator word and does not depend on txDataIn.
- R4: Bit 0 of each transmit word is the earliest sequence bit and bit 9 the latest. Every generated bit b[n] equals b[n-6] xor b[n-7] (polynomial x^7 + x^6 + 1). Successive words continue the sequence without a gap.
- R5: The generated bit stream repeats with a period of 127 bits.
- R6: The first receive word sampled after testEn rises only seeds the checker. passFlag is 1 after that edge, whatever the word holds.
- R7: A receive stream that follows the sequence at any of the 127 phases keeps passFlag at 1.
- R8: A receive word in which any bit differs from the checker's prediction drives passFlag to 0 on the edge that samples that word.
- R9: With stickyMode at 0, passFlag returns to 1 on the second error-free word after a word with one flipped bit.
- R10: With stickyMode at 1, passFlag stays 0 after a failure for as long as testEn stays 1.
- R11: Sampling testEn low clears the latched failure and reseeds both registers. A new stream at a different phase then passes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Word clock |
| rstN | input | 1 | Asynchronous active-low reset |
| testEn | input | 1 | Enables the generator and the checker together |
| stickyMode | input | 1 | 0: passFlag shows the last word; 1: passFlag shows the latched result |
| txDataIn | input | 10 | User transmit word |
| txDataOut | output | 10 | Transmit word toward the serializer; bit 0 is sent first |
| rxDataIn | input | 10 | Received word from the deserializer; bit 0 is the earliest |
| passFlag | output | 1 | 1 = pass, 0 = failure detected |

## Verification
The hardest conditions to reach are the checker locking at an arbitrary phase and the way one flipped bit spreads through a predictor that takes its history from the received stream. The bench sweeps all 127 starting phases and checks that every word passes. It then flips each of the ten bit positions in turn. For each one it confirms a failure on that word and, in live mode, recovery two words later. In sticky mode it confirms the failure holds until the enable is dropped.

// File: rtl/prbs_bist_pkg.sv
package prbs_bist_pkg;

  localparam int unsigned DEF_WORD_W = 10;
  localparam int unsigned DEF_LFSR_W = 7;

  // Strobes issued by the control module to the datapath each word clock.
  typedef struct packed {
    logic genLoad;     // reload generator from seed
    logic genStep;     // advance generator one word and drive it out
    logic chkLoad;     // seed checker history from received word
    logic chkCompare;  // compare received word against prediction
  } bistStrobes_t;

endpackage

// File: rtl/prbs_bist_datapath.sv
module prbs_bist_datapath
  import prbs_bist_pkg::*;
#(
  parameter int unsigned WORD_W = DEF_WORD_W,
  parameter int unsigned LFSR_W = DEF_LFSR_W,
  parameter logic [LFSR_W-1:0] SEED = {LFSR_W{1'b1}}
) (
  input  logic              clk,
  input  logic              rstN,
  input  bistStrobes_t      strobes,
  input  logic [WORD_W-1:0] txUser,
  input  logic [WORD_W-1:0] rxWord,
  output logic [WORD_W-1:0] txOut,
  output logic              wordMismatch
);

  localparam int unsigned TAP_A = LFSR_W - 1;  // x^7 term
  localparam int unsigned TAP_B = LFSR_W - 2;  // x^6 term

  logic [LFSR_W-1:0] genState;
  logic [LFSR_W-1:0] genNext;
  logic [LFSR_W-1:0] chkState;
  logic [LFSR_W-1:0] chkNext;
  logic [WORD_W-1:0] genWord;
  logic [WORD_W-1:0] predWord;

  // Generator: ten feedback steps per word, earliest bit in position 0.
  always_comb begin : genUnroll
    logic [LFSR_W-1:0] st;
    st = genState;
    for (int i = 0; i < WORD_W; i++) begin
      genWord[i] = st[TAP_A] ^ st[TAP_B];
      st = {st[LFSR_W-2:0], genWord[i]};
    end
    genNext = st;
  end

  // Checker: predicts each bit from received history (self-synchronising).
  always_comb begin : chkUnroll
    logic [LFSR_W-1:0] st;
    st = chkState;
    for (int i = 0; i < WORD_W; i++) begin
      predWord[i] = st[TAP_A] ^ st[TAP_B];
      st = {st[LFSR_W-2:0], rxWord[i]};
    end
    chkNext = st;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      genState <= SEED;
    end else if (strobes.genLoad) begin
      genState <= SEED;
    end else if (strobes.genStep) begin
      genState <= genNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chkState <= '0;
    end else if (strobes.chkLoad || strobes.chkCompare) begin
      chkState <= chkNext;
    end
  end

  assign txOut        = strobes.genStep ? genWord : txUser;
  assign wordMismatch = strobes.chkCompare && (predWord != rxWord);

endmodule

// File: rtl/prbs_bist_control.sv
module prbs_bist_control
  import prbs_bist_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         testEn,
  input  logic         stickyMode,
  input  logic         wordMismatch,
  output bistStrobes_t strobes,
  output logic         passFlag
);

  logic seeded;
  logic errNow;
  logic stickyFail;

  always_comb begin
    strobes.genLoad    = !testEn;
    strobes.genStep    = testEn;
    strobes.chkLoad    = testEn && !seeded;
    strobes.chkCompare = testEn && seeded;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seeded     <= 1'b0;
      errNow     <= 1'b0;
      stickyFail <= 1'b0;
    end else if (!testEn) begin
      seeded     <= 1'b0;
      errNow     <= 1'b0;
      stickyFail <= 1'b0;
    end else begin
      seeded     <= 1'b1;
      errNow     <= wordMismatch;
      stickyFail <= stickyFail | wordMismatch;
    end
  end

  assign passFlag = stickyMode ? !stickyFail : !errNow;

endmodule

// File: rtl/prbs_bist.sv
module prbs_bist
  import prbs_bist_pkg::*;
#(
  parameter int unsigned WORD_W = DEF_WORD_W,
  parameter int unsigned LFSR_W = DEF_LFSR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              testEn,
  input  logic              stickyMode,
  input  logic [WORD_W-1:0] txDataIn,
  output logic [WORD_W-1:0] txDataOut,
  input  logic [WORD_W-1:0] rxDataIn,
  output logic              passFlag
);

  bistStrobes_t strobes;
  logic         wordMismatch;

  prbs_bist_control i_control (
    .clk          (clk),
    .rstN         (rstN),
    .testEn       (testEn),
    .stickyMode   (stickyMode),
    .wordMismatch (wordMismatch),
    .strobes      (strobes),
    .passFlag     (passFlag)
  );

  prbs_bist_datapath #(
    .WORD_W (WORD_W),
    .LFSR_W (LFSR_W)
  ) i_datapath (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .txUser       (txDataIn),
    .rxWord       (rxDataIn),
    .txOut        (txDataOut),
    .wordMismatch (wordMismatch)
  );

endmodule

// File: rtl/prbs_bist_checks.sv
module prbs_bist_checks #(
  parameter int unsigned WORD_W = 10,
  parameter int unsigned LFSR_W = 7
) (
  input logic              clk,
  input logic              rstN,
  input logic              testEn,
  input logic              stickyMode,
  input logic [WORD_W-1:0] txDataIn,
  input logic [WORD_W-1:0] txDataOut,
  input logic              passFlag
);

  always @(posedge clk) begin
    if (!rstN) begin
      assert_reset_pass_R1: assert (passFlag);
    end
  end

  assert_user_bypass_R2: assert property (@(posedge clk) disable iff (!rstN)
    !testEn |-> txDataOut == txDataIn);

  assert_idle_pass_R2: assert property (@(posedge clk) disable iff (!rstN)
    !testEn |=> passFlag);

  genvar g;
  generate
    for (g = LFSR_W; g < WORD_W; g++) begin : gRecur
      assert_gen_recurrence_R4: assert property (@(posedge clk) disable iff (!rstN)
        testEn |-> txDataOut[g] == (txDataOut[g-LFSR_W+1] ^ txDataOut[g-LFSR_W]));
    end
  endgenerate

  assert_seed_word_pass_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(testEn) |=> passFlag);

  assert_sticky_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (testEn && stickyMode && !passFlag) |=> (!testEn || !stickyMode || !passFlag));

endmodule

bind prbs_bist prbs_bist_checks #(
  .WORD_W (WORD_W),
  .LFSR_W (LFSR_W)
) i_prbs_bist_checks (
  .clk        (clk),
  .rstN       (rstN),
  .testEn     (testEn),
  .stickyMode (stickyMode),
  .txDataIn   (txDataIn),
  .txDataOut  (txDataOut),
  .passFlag   (passFlag)
);

// File: tb/test_prbs_bist.sv
`timescale 1ns/1ps
module test_prbs_bist;

  localparam int W = 10;
  localparam int NREF = 1600;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         testEn = 1'b0;
  logic         stickyMode = 1'b0;
  logic [W-1:0] txDataIn = '0;
  logic [W-1:0] txDataOut;
  logic [W-1:0] rxDataIn = '0;
  logic         passFlag;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;
  bit refBits [0:NREF-1];
  bit capt [0:NREF-1];

  always #4 clk = ~clk;  // 125 MHz

  prbs_bist i_prbs_bist (
    .clk(clk), .rstN(rstN), .testEn(testEn), .stickyMode(stickyMode),
    .txDataIn(txDataIn), .txDataOut(txDataOut), .rxDataIn(rxDataIn),
    .passFlag(passFlag)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cycle();
    @(posedge clk);
    #1;
  endtask

  function automatic logic [W-1:0] refWord(input int start);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = refBits[start + i];
    return r;
  endfunction

  // Restart the test: one clock with the enable low, then enable again.
  task automatic restart();
    testEn = 1'b0;
    cycle();
    testEn = 1'b1;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    // Reference sequence: seven ones of history, then b[n] = b[n-6] ^ b[n-7].
    for (int k = 0; k < 7; k++) refBits[k] = 1'b1;
    for (int k = 7; k < NREF; k++) refBits[k] = refBits[k-6] ^ refBits[k-7];

    // R1: reset state
    #2;
    chk(passFlag == 1'b1, "R1 pass during reset", passFlag, 1);
    cycle(); cycle();
    rstN = 1'b1;
    cycle();
    chk(passFlag == 1'b1, "R1 pass after reset", passFlag, 1);

    // R2: pass-through sweep of every user word with the test disabled
    for (int v = 0; v < 1024; v++) begin
      txDataIn = v[W-1:0];
      rxDataIn = ~v[W-1:0];
      stickyMode = v[0];
      #1;
      chk(txDataOut == v[W-1:0], "R2 bypass", txDataOut, v);
      cycle();
      chk(passFlag == 1'b1, "R2 idle pass", passFlag, 1);
    end

    // R1/R3/R4/R5: generator from seed, loopback into checker
    stickyMode = 1'b0;
    testEn = 1'b1;
    for (int w = 0; w < 141; w++) begin
      txDataIn = (w * 37 + 5) % 1024;
      #1;
      chk(txDataOut == refWord(7 + 10*w),
          (w == 0) ? "R1 first word from seed" : "R3 R4 generator word",
          txDataOut, refWord(7 + 10*w));
      for (int i = 0; i < W; i++) capt[10*w + i] = txDataOut[i];
      if (w >= 13) begin
        logic [W-1:0] old;
        for (int i = 0; i < W; i++) old[i] = capt[10*w + i - 127];
        chk(txDataOut == old, "R5 period 127", txDataOut, old);
      end
      rxDataIn = txDataOut;
      cycle();
      chk(passFlag == 1'b1, "R7 loopback pass", passFlag, 1);
    end

    // R6/R7: every starting phase of the received stream
    for (int p = 0; p < 127; p++) begin
      restart();
      for (int w = 0; w < 6; w++) begin
        rxDataIn = refWord(7 + p + 10*w);
        cycle();
        chk(passFlag == 1'b1, (w == 0) ? "R6 seed word" : "R7 phase pass", passFlag, 1);
      end
    end

    // R6: garbage seed word still passes
    restart();
    rxDataIn = 10'h2A5;
    cycle();
    chk(passFlag == 1'b1, "R6 garbage seed", passFlag, 1);

    // R8/R9: live mode, flip each bit position
    stickyMode = 1'b0;
    for (int j = 0; j < W; j++) begin
      int p;
      p = (j * 13) % 127;
      restart();
      for (int w = 0; w < 3; w++) begin
        rxDataIn = refWord(7 + p + 10*w);
        cycle();
      end
      rxDataIn = refWord(7 + p + 30) ^ (10'd1 << j);
      cycle();
      chk(passFlag == 1'b0, "R8 flipped bit fails", passFlag, 0);
      rxDataIn = refWord(7 + p + 40);
      cycle();
      rxDataIn = refWord(7 + p + 50);
      cycle();
      chk(passFlag == 1'b1, "R9 live recovery", passFlag, 1);
    end

    // R10/R11: sticky mode
    stickyMode = 1'b1;
    restart();
    for (int w = 0; w < 4; w++) begin
      rxDataIn = refWord(57 + 10*w);
      cycle();
      chk(passFlag == 1'b1, "R10 sticky clean", passFlag, 1);
    end
    rxDataIn = refWord(97) ^ 10'h010;
    cycle();
    chk(passFlag == 1'b0, "R8 sticky fail", passFlag, 0);
    for (int w = 5; w < 25; w++) begin
      rxDataIn = refWord(57 + 10*w);
      cycle();
      chk(passFlag == 1'b0, "R10 sticky hold", passFlag, 0);
    end
    testEn = 1'b0;
    cycle();
    chk(passFlag == 1'b1, "R11 clear on disable", passFlag, 1);
    testEn = 1'b1;
    for (int w = 0; w < 8; w++) begin
      rxDataIn = refWord(7 + 88 + 10*w);
      cycle();
      chk(passFlag == 1'b1, "R11 reseed new phase", passFlag, 1);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule